// File: doc/BRIEF.md
# Self-Timed Program Cycle Sequencer

This block carries out the slow, self-timed part of a serial EEPROM's erase and write instructions. A serial front-end (not part of this block) decodes an instruction and hands it over with a one-cycle `cmd_valid` pulse. The sequencer holds that instruction as pending. It launches the instruction on the first falling edge of chip select that follows. After launch it times each phase from its own system clock and never looks at the serial clock.

Four operations are supported: erase of one location, write of one location with a built-in erase first, erase of the whole array, and write of one data value into every location. Whole-array operations step a location counter from word 0 to the last word. Each location goes through an erase phase and, for writes, a program phase, each lasting a parameterised number of clocks. The storage is a register-file array of 16-bit words. In byte organisation a single-location operation touches only one byte lane of a word. A read port exposes the array.

While an operation runs, the shared data-out pin reports busy (low) or ready (high) whenever chip select is high. Instructions offered while the sequencer is busy are discarded.

Top module: `eep_prog_seq`

## Requirements
- R1: After synchronous reset `busy` is 0, every word reads 16'hFFFF, and `do_drive` is 0 even with `cs` high.
- R2: An accepted command launches only at a clock edge where `cs` is sampled low and was high at the previous edge. A command that arrives in the launch cycle is dropped. Without such an edge a pending command waits and nothing runs.
- R3: `busy` rises in the cycle after launch. It stays high for ERASE_CYC clocks per erased location, plus PROG_CYC clocks per programmed location. The op codes are 0 erase one, 1 write one, 2 erase all and 3 write all.
- R4: A single write (op 1) first stores all ones into the target lanes at the end of its erase phase. It stores the data only at the end of the following program phase.
- R5: Op 0 and op 2 leave every affected byte at 8'hFF and leave every other byte unchanged.
- R6: Op 3 stores the same value into every word. In x16 mode the value is `cmd_data`. In x8 mode it is `{cmd_data[7:0], cmd_data[7:0]}`.
- R7: When `org_x8` is 1, a single-location op addresses word `cmd_addr[AW:1]`. It touches bits 15:8 if `cmd_addr[0]` is 1 and bits 7:0 otherwise, writing `cmd_data[7:0]`. When `org_x8` is 0 it uses word `cmd_addr[AW-1:0]` and all 16 bits.
- R8: From launch until a falling `cs` seen while idle, `do_drive` equals `cs`. During that span `do_level` is 0 while busy and 1 when done. Outside it `do_drive` is 0.
- R9: A `cmd_valid` pulse in any cycle where the sequencer is busy, including the cycle of its final array write, is discarded. A later `cs` fall does not launch it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| org_x8 | input | 1 | 1 selects byte organisation, sampled with the command |
| cmd_valid | input | 1 | One-cycle pulse presenting a complete, enabled instruction |
| cmd_op | input | 2 | Operation code (0 erase, 1 write, 2 erase all, 3 write all) |
| cmd_addr | input | AW+1 | Byte address (x8) or word address in the low AW bits (x16) |
| cmd_data | input | 16 | Write data (low byte used in x8 mode) |
| cs | input | 1 | Chip select, synchronous to `clk` |
| rd_addr | input | AW | Array read word address |
| rd_data | output | 16 | Array read data, combinational |
| busy | output | 1 | Operation in progress |
| do_drive | output | 1 | Data-out enable for status reporting |
| do_level | output | 1 | Status level: 0 busy, 1 ready |

## Verification
Two events can collide in one cycle, and the bench provokes both. A new instruction can arrive on the same edge that launches the pending one. A new instruction can also arrive on the edge that commits the last location of a write-all, the moment just before `busy` falls. The bench times the second case from its own model's remaining-cycle count. In both cases the expected result is a dropped command. This is judged first by the per-cycle model comparison and then by an explicit check that a later `cs` fall starts nothing and leaves the array unchanged.

// File: rtl/eep_seq_pkg.sv
package eep_seq_pkg;

    localparam int WORD_W = 16;

    typedef enum logic [1:0] {
        OP_ERASE = 2'd0,
        OP_WRITE = 2'd1,
        OP_ERAL  = 2'd2,
        OP_WRAL  = 2'd3
    } prog_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ERASE = 2'd1,
        PH_PROG  = 2'd2
    } phase_e;

    typedef struct packed {
        prog_op_e            op;
        logic                x8;
        logic [WORD_W-1:0]   data;
    } cmd_t;

    function automatic logic op_is_all(prog_op_e op);
        return (op == OP_ERAL) || (op == OP_WRAL);
    endfunction

    function automatic logic op_programs(prog_op_e op);
        return (op == OP_WRITE) || (op == OP_WRAL);
    endfunction

    // byte-lane enables: whole word unless a single op in byte mode
    function automatic logic [1:0] lane_sel(logic x8, logic lsb, logic whole);
        if (whole || !x8)
            return 2'b11;
        return lsb ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [WORD_W-1:0] spread(logic [WORD_W-1:0] d, logic x8);
        return x8 ? {d[7:0], d[7:0]} : d;
    endfunction

endpackage

// File: rtl/eep_cmd_hold.sv
module eep_cmd_hold
    import eep_seq_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                idle,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [AW:0]         cmd_addr,
    input  logic [WORD_W-1:0]   cmd_data,
    input  logic                org_x8,
    input  logic                cs,
    output logic                launch,
    output logic                cs_fall,
    output cmd_t                held,
    output logic [AW:0]         held_addr
);

    logic cs_q;
    logic pend_q;

    assign cs_fall = cs_q && !cs;
    assign launch  = cs_fall && pend_q && idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q      <= 1'b0;
            pend_q    <= 1'b0;
            held      <= '{op: OP_ERASE, x8: 1'b0, data: '0};
            held_addr <= '0;
        end else begin
            cs_q <= cs;
            if (launch) begin
                pend_q <= 1'b0;
            end else if (cmd_valid && idle) begin
                pend_q    <= 1'b1;
                held      <= '{op: prog_op_e'(cmd_op), x8: org_x8, data: cmd_data};
                held_addr <= cmd_addr;
            end
        end
    end

    AST_DROP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (!idle && cmd_valid) |=> !pend_q) else $error("busy command kept"); // R9

    AST_LAUNCH_CONSUMES: assert property (@(posedge clk) disable iff (rst)
        launch |=> !pend_q) else $error("pending survived launch"); // R2

endmodule

// File: rtl/eep_phase_timer.sv
module eep_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  logic [CW-1:0] limit,
    output logic          expire
);

    logic [CW-1:0] cnt_q;

    assign expire = active && (cnt_q == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!active || expire)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + CW'(1);
    end

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt_q < limit)) else $error("phase counter overran"); // R3

endmodule

// File: rtl/eep_word_array.sv
module eep_word_array
    import eep_seq_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int AW    = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [1:0]          wmask,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [AW-1:0]       raddr,
    output logic [WORD_W-1:0]   rdata
);

    logic [WORD_W-1:0] cells_q [WORDS];

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            for (genvar b = 0; b < 2; b++) begin : g_lane
                always_ff @(posedge clk) begin
                    if (rst)
                        cells_q[w][b*8 +: 8] <= 8'hFF;
                    else if (we && wmask[b] && (waddr == AW'(w)))
                        cells_q[w][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
        end
    endgenerate

    assign rdata = cells_q[raddr];

    AST_MASK_LIVE: assert property (@(posedge clk) disable iff (rst)
        we |-> (wmask != 2'b00)) else $error("write with no lane"); // R7

endmodule

// File: rtl/eep_prog_seq.sv
module eep_prog_seq
    import eep_seq_pkg::*;
#(
    parameter  int WORDS     = 16,
    parameter  int ERASE_CYC = 4,
    parameter  int PROG_CYC  = 6,
    localparam int AW        = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              org_x8,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [AW:0]       cmd_addr,
    input  logic [15:0]       cmd_data,
    input  logic              cs,
    input  logic [AW-1:0]     rd_addr,
    output logic [15:0]       rd_data,
    output logic              busy,
    output logic              do_drive,
    output logic              do_level
);

    localparam int           MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int           CW   = $clog2(MAXC + 1);
    localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

    phase_e              phase_q;
    logic [AW-1:0]       loc_q;
    logic                win_q;
    logic                launch, cs_fall, expire, idle;
    cmd_t                held;
    logic [AW:0]         held_addr;
    logic [AW-1:0]       held_word;
    logic                all_op;
    logic [CW-1:0]       limit;
    logic                we;
    logic [1:0]          wmask;
    logic [WORD_W-1:0]   wdata;

    assign idle      = (phase_q == PH_IDLE);
    assign all_op    = op_is_all(held.op);
    assign held_word = held.x8 ? held_addr[AW:1] : held_addr[AW-1:0];
    assign limit     = (phase_q == PH_PROG) ? CW'(PROG_CYC) : CW'(ERASE_CYC);

    eep_cmd_hold #(.AW(AW)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .idle      (idle),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .org_x8    (org_x8),
        .cs        (cs),
        .launch    (launch),
        .cs_fall   (cs_fall),
        .held      (held),
        .held_addr (held_addr)
    );

    eep_phase_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .active (!idle),
        .limit  (limit),
        .expire (expire)
    );

    // commit one location's phase at the end of its timed window
    assign we    = expire;
    assign wmask = lane_sel(held.x8, held_addr[0], all_op);
    assign wdata = (phase_q == PH_ERASE) ? '1 : spread(held.data, held.x8);

    eep_word_array #(.WORDS(WORDS), .AW(AW)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (loc_q),
        .wmask (wmask),
        .wdata (wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            loc_q   <= '0;
        end else if (launch) begin
            phase_q <= PH_ERASE;
            loc_q   <= all_op ? '0 : held_word;
        end else if (expire) begin
            if (phase_q == PH_ERASE && op_programs(held.op)) begin
                phase_q <= PH_PROG;
            end else if (all_op && loc_q != LAST) begin
                loc_q   <= loc_q + AW'(1);
                phase_q <= PH_ERASE;
            end else begin
                phase_q <= PH_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            win_q <= 1'b0;
        else if (launch)
            win_q <= 1'b1;
        else if (cs_fall && idle)
            win_q <= 1'b0;
    end

    assign busy     = !idle;
    assign do_drive = cs && win_q;
    assign do_level = idle;

    AST_IDLE_NEEDS_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        (idle && !launch) |=> (phase_q == PH_IDLE)) else $error("start without cs fall"); // R2

    AST_PROG_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PROG) |-> op_programs(held.op)) else $error("program phase on erase op"); // R4

    AST_SINGLE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (!idle && !all_op) |-> (loc_q == held_word)) else $error("single op moved location"); // R5

    AST_STATUS_OPEN: assert property (@(posedge clk) disable iff (rst)
        launch |=> (win_q && busy)) else $error("status window not opened"); // R8

endmodule

// File: tb/eep_prog_seq_tb.sv
module eep_prog_seq_tb;

    localparam int WORDS = 16;
    localparam int EC    = 4;
    localparam int PC    = 6;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          org_x8 = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [AW:0]   cmd_addr = '0;
    logic [15:0]   cmd_data = '0;
    logic          cs = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0]   rd_data;
    logic          busy, do_drive, do_level;

    eep_prog_seq #(.WORDS(WORDS), .ERASE_CYC(EC), .PROG_CYC(PC)) u_dut (
        .clk(clk), .rst(rst), .org_x8(org_x8), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cs(cs),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
        .do_drive(do_drive), .do_level(do_level)
    );

    always #10 clk = ~clk;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    task automatic check(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_mem [WORDS];
    bit m_pend, m_busy, m_win, m_csq, m_x8, m_stage;
    int m_op, m_addr, m_data, m_left, m_loc;
    bit was_busy, fall, go;

    function automatic int m_word();
        return m_x8 ? ((m_addr >> 1) & (WORDS - 1)) : (m_addr & (WORDS - 1));
    endfunction

    task automatic m_commit();
        int mask;
        int val;
        if (m_op >= 2 || !m_x8) mask = 16'hFFFF;
        else mask = (m_addr & 1) ? 16'hFF00 : 16'h00FF;
        if (m_stage == 0) val = 16'hFFFF;
        else val = m_x8 ? ((m_data & 255) * 257) : (m_data & 16'hFFFF);
        m_mem[m_loc] = ((m_mem[m_loc] & ~mask) | (val & mask)) & 16'hFFFF;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            for (int i = 0; i < WORDS; i++) m_mem[i] = 16'hFFFF;
            m_pend = 0; m_busy = 0; m_win = 0; m_csq = 0;
        end else begin
            was_busy = m_busy;
            fall     = m_csq && !cs;
            go       = fall && m_pend && !was_busy;
            if (was_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_commit();
                    if (m_stage == 0 && (m_op == 1 || m_op == 3)) begin
                        m_stage = 1; m_left = PC;
                    end else if (m_op >= 2 && m_loc < WORDS - 1) begin
                        m_loc++; m_stage = 0; m_left = EC;
                    end else begin
                        m_busy = 0;
                    end
                end
            end
            if (go) begin
                m_busy = 1; m_stage = 0; m_left = EC;
                m_loc  = (m_op >= 2) ? 0 : m_word();
                m_pend = 0; m_win = 1;
            end else if (cmd_valid && !was_busy) begin
                m_pend = 1; m_op = cmd_op; m_addr = cmd_addr;
                m_data = cmd_data; m_x8 = org_x8;
            end
            if (fall && !was_busy && !go) m_win = 0;
            m_csq = cs;
        end
    end

    // per-cycle comparison, away from the clock edge
    always @(posedge clk) begin
        #5;
        if (!rst) begin
            check(busy == m_busy, "R3 busy vs model", busy, m_busy);
            check(do_drive == (cs && m_win), "R8 do_drive vs model", do_drive, cs && m_win);
            if (do_drive)
                check(do_level == !m_busy, "R8 do_level vs model", do_level, !m_busy);
            check(rd_data == m_mem[rd_addr], "R5 array word vs model", rd_data, m_mem[rd_addr]);
        end
    end

    // read address sweeps unless a directed peek holds it
    bit            hold_rd = 0;
    logic [AW-1:0] rd_fix  = '0;
    always @(negedge clk) rd_addr <= hold_rd ? rd_fix : rd_addr + 1'b1;

    task automatic peek(int addr, int exp, string req);
        hold_rd = 1; rd_fix = addr[AW-1:0];
        @(negedge clk); #1;
        check(rd_data == exp[15:0], req, rd_data, exp);
        hold_rd = 0;
    endtask

    task automatic issue(int op, int addr, int data, bit x8);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op[1:0]; cmd_addr = addr[AW:0];
        cmd_data = data[15:0]; org_x8 = x8;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic fall_cs();
        @(negedge clk); cs = 1;
        repeat (2) @(negedge clk);
        cs = 0;
    endtask

    task automatic wait_done();
        @(negedge clk); cs = 1;
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        cs = 1;
        @(negedge clk); rst = 0;
        @(negedge clk); #1;
        check(busy == 0, "R1 busy after reset", busy, 0);
        check(do_drive == 0, "R1 no status drive after reset", do_drive, 0);
        peek(7, 16'hFFFF, "R1 array erased after reset");

        // x16 single write: erase-before-write visible mid-operation
        issue(1, 3, 16'hA5C3, 0);
        fall_cs();
        hold_rd = 1; rd_fix = 3;
        repeat (5) @(negedge clk); #1;
        check(rd_data == 16'hFFFF, "R4 target all ones after erase phase", rd_data, 16'hFFFF);
        check(busy == 1, "R3 still busy in program phase", busy, 1);
        hold_rd = 0;
        @(negedge clk); cs = 1; #1;
        check(do_drive == 1 && do_level == 0, "R8 busy shown low on DO", {do_drive, do_level}, 2'b10);
        wait_done();
        #1 check(do_drive == 1 && do_level == 1, "R8 ready shown high on DO", {do_drive, do_level}, 2'b11);
        peek(3, 16'hA5C3, "R4 word programmed after write");

        // pending command waits without a cs fall
        cs = 0;
        issue(0, 3, 0, 0);
        repeat (20) @(negedge clk);
        #1 check(busy == 0, "R2 no start without cs fall", busy, 0);
        fall_cs();
        repeat (2) @(negedge clk); #1;
        check(busy == 1, "R2 start after cs fall", busy, 1);
        wait_done();
        peek(3, 16'hFFFF, "R5 single erase gives ones");

        // byte organisation lane mapping
        issue(1, 11, 16'h003C, 1);
        fall_cs(); wait_done();
        peek(5, 16'h3CFF, "R7 odd byte to upper lane");
        issue(1, 10, 16'h0081, 1);
        fall_cs(); wait_done();
        peek(5, 16'h3C81, "R7 even byte to lower lane");
        issue(0, 11, 0, 1);
        fall_cs(); wait_done();
        peek(5, 16'hFF81, "R5 byte erase keeps other lane");

        // write-all, command during busy and at the final commit
        issue(3, 0, 16'h1234, 0);
        fall_cs();
        repeat (30) @(negedge clk);
        cmd_valid = 1; cmd_op = 2'd0; cmd_addr = 0;
        @(negedge clk); cmd_valid = 0;
        while (!(m_busy && m_left == 1 && m_stage == 1 && m_loc == WORDS - 1)) @(negedge clk);
        cmd_valid = 1; cmd_op = 2'd2;
        @(negedge clk); cmd_valid = 0;
        wait_done();
        peek(0, 16'h1234, "R6 write-all first word");
        peek(15, 16'h1234, "R6 write-all last word");
        fall_cs();
        repeat (4) @(negedge clk); #1;
        check(busy == 0, "R9 busy-time commands dropped", busy, 0);
        peek(9, 16'h1234, "R9 array untouched by dropped command");

        // erase-all
        cs = 1;
        issue(2, 0, 0, 0);
        fall_cs(); wait_done();
        peek(8, 16'hFFFF, "R5 erase-all gives ones");
        #1 check(do_drive == 1, "R8 window open after erase-all", do_drive, 1);

        // x8 write-all, with a command in the launch cycle
        issue(3, 0, 16'h005A, 1);
        @(negedge clk); cs = 1;
        repeat (2) @(negedge clk);
        cs = 0; cmd_valid = 1; cmd_op = 2'd0; cmd_addr = 4; org_x8 = 0;
        @(negedge clk); cmd_valid = 0;
        wait_done();
        peek(4, 16'h5A5A, "R6 byte write-all replicated");
        fall_cs();
        repeat (4) @(negedge clk); #1;
        check(busy == 0, "R2 launch-cycle command dropped", busy, 0);
        cs = 1;
        @(negedge clk); #1;
        check(do_drive == 0, "R8 window closed after idle cs fall", do_drive, 0);
        peek(4, 16'h5A5A, "R9 no erase from dropped command");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule